// File: doc/BRIEF.md
# Fractional Main-Scan Pixel Reducer

This block shrinks a scan line along the main scan direction by a programmable ratio with a resolution of 1/128. Each incoming pixel adds the ratio step to a wrapping phase accumulator. A pixel is kept when the accumulator carries past a full unit, and dropped otherwise. The step is the ratio code plus one, so the block covers every ratio from 1/128 up to unity. The first pixel of every line is always kept, and the phase restarts there.

Pixels are either binary or 6-bit multilevel (halftone). In binary mode, bit 0 carries the pixel and 1 means black. A black pixel that falls on a dropped position is remembered and merged into the next kept pixel, so that thin strokes survive the shrink. Halftone data does not tolerate heavy decimation, so in halftone mode a ratio below one half is raised to one half and a flag reports this. The downstream side sees the result in one of two ways. It can receive a strobe that fires only for kept pixels, which stands in for a gated pixel clock. Or it can receive a strobe for every pixel together with a keep mask.

The ratio, the data kind and the output style are all sampled on the line-start pixel and held for the rest of the line.

Top module: `hscan_shrinker`

## Requirements
- R1: Outputs are registered with one cycle of latency. Out of reset, `out_valid`, `out_keep`, `out_pix` and `out_clamped` are all zero. A cycle with `in_valid` low produces `out_valid` low on the next cycle.
- R2: With effective step s (ratio code + 1), pixel i of a line (i counted from 0) is kept when i = 0, or when floor(i*s/128) differs from floor((i-1)*s/128). A line of N pixels therefore keeps 1 + floor((N-1)*s/128) pixels.
- R3: Ratio code 127 (s = 128) keeps every pixel. In halftone mode each kept pixel equals the input unchanged.
- R4: The pixel that carries `in_line_start` (qualified by `in_valid`) is always kept, and the phase accumulator restarts from zero there.
- R5: In binary mode (`cfg_halftone` = 0), bit 0 of a kept output pixel is the OR of its own bit 0 and bit 0 of every pixel dropped since the previous kept pixel of the same line. Bits 5..1 of a kept pixel are zero. The remembered black value is cleared at line start and whenever a pixel is kept.
- R6: In halftone mode (`cfg_halftone` = 1), no black merging takes place. A step below 64 is raised to 64, and in that case `out_clamped` is 1 from the output of the line's first pixel until the next line start. In every other case `out_clamped` is 0.
- R7: Ratio code, halftone flag and emit mode are sampled on the line-start pixel. Changes to them later in the line have no effect on that line.
- R8: Gated emit mode (`cfg_emit` = 0): `out_valid` pulses only for kept pixels, and `out_keep` equals `out_valid`.
- R9: Masked emit mode (`cfg_emit` = 1): `out_valid` pulses for every input pixel and `out_keep` marks the kept ones. On a dropped pixel, in either mode, `out_pix` carries the raw input pixel.
- R10: The accumulator places no limit on line length. An 8192-pixel line is reduced according to R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present this cycle |
| in_line_start | input | 1 | Marks the first pixel of a line |
| in_pix | input | 6 | Input pixel; bit 0 is the binary value |
| cfg_ratio | input | 7 | Ratio code; step = code + 1 in 1/128 units |
| cfg_halftone | input | 1 | 1 = multilevel data, 0 = binary data |
| cfg_emit | input | 1 | 0 = gated strobe, 1 = strobe plus keep mask |
| out_valid | output | 1 | Output pixel strobe |
| out_keep | output | 1 | Pixel belongs to the reduced line |
| out_pix | output | 6 | Output pixel |
| out_clamped | output | 1 | Halftone ratio was raised to one half |

## Verification
On every cycle, the assertions check the following:
- the idle-to-idle latency;
- that a line-start pixel is always kept;
- that a unit ratio drops nothing;
- the strobe and mask relation of each emit mode;
- the zero upper bits of kept binary pixels;
- the halftone step floor;
- that the sampled configuration stays still within a line.

Other behaviour needs a line-level model, and only the bench scenarios show it. This covers the exact keep pattern for a given step, the pixel count of a reduced line, a black pixel merged into the following kept pixel, and the behaviour over a full 8192-pixel line.

// File: rtl/shrink_pkg.sv
package shrink_pkg;
    typedef enum logic {
        EMIT_GATED  = 1'b0,
        EMIT_MASKED = 1'b1
    } emit_mode_e;
endpackage

// File: rtl/shrink_ratio_limit.sv
module shrink_ratio_limit #(
    parameter int RATIO_W = 7,
    parameter int HT_MIN  = 64
) (
    input  logic [RATIO_W-1:0] code,
    input  logic               halftone,
    output logic [RATIO_W:0]   step,
    output logic               clamped
);
    localparam int STEP_W = RATIO_W + 1;
    localparam logic [STEP_W-1:0] FLOOR = STEP_W'(HT_MIN);

    logic [STEP_W-1:0] raw_d;

    always_comb begin
        raw_d   = {1'b0, code} + STEP_W'(1);
        clamped = halftone && (raw_d < FLOOR);
        step    = clamped ? FLOOR : raw_d;
    end
endmodule

// File: rtl/shrink_phase.sv
module shrink_phase #(
    parameter int RATIO_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             restart,
    input  logic [RATIO_W:0] step,
    output logic             keep
);
    localparam int FULL = 1 << RATIO_W;

    typedef struct packed {
        logic [RATIO_W-1:0] acc;
        logic [RATIO_W-1:0] gap;
    } phase_t;

    phase_t st_q, st_d;
    logic [RATIO_W:0] sum_d;

    always_comb begin
        st_d  = st_q;
        sum_d = {1'b0, st_q.acc} + step;
        keep  = adv && (restart || sum_d[RATIO_W]);
        if (adv) begin
            st_d.acc = restart ? '0 : sum_d[RATIO_W-1:0];
            st_d.gap = keep ? '0 : st_q.gap + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: with a step of at least 1, no run of drops reaches a full unit.
    a_r2_bounded_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !keep) |-> (int'(st_q.gap) < FULL - 1));
endmodule

// File: rtl/shrink_black_carry.sv
module shrink_black_carry (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic restart,
    input  logic keep,
    input  logic binary,
    input  logic bit_in,
    output logic merged
);
    logic carry_q, carry_d;

    always_comb begin
        merged  = bit_in | (carry_q & ~restart);
        carry_d = carry_q;
        if (adv) begin
            if (restart || keep || !binary) carry_d = 1'b0;
            else                            carry_d = carry_q | bit_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) carry_q <= 1'b0;
        else        carry_q <= carry_d;
    end
endmodule

// File: rtl/hscan_shrinker.sv
module hscan_shrinker
    import shrink_pkg::*;
#(
    parameter int PIX_W   = 6,
    parameter int RATIO_W = 7,
    parameter int HT_MIN  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_line_start,
    input  logic [PIX_W-1:0]   in_pix,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic               cfg_halftone,
    input  logic               cfg_emit,
    output logic               out_valid,
    output logic               out_keep,
    output logic [PIX_W-1:0]   out_pix,
    output logic               out_clamped
);
    localparam int STEP_W = RATIO_W + 1;
    localparam logic [STEP_W-1:0] FULL = STEP_W'(1 << RATIO_W);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              clamped;
        logic              halftone;
        emit_mode_e        emit;
    } cfg_t;

    typedef struct packed {
        logic             valid;
        logic             keep;
        logic [PIX_W-1:0] pix;
        logic             clamped;
    } out_t;

    cfg_t cfg_q, cfg_d, cur;
    out_t o_q, o_d;
    logic              start_w, keep_w, merged_w, live_clamp_w;
    logic [STEP_W-1:0] live_step_w;

    shrink_ratio_limit #(.RATIO_W(RATIO_W), .HT_MIN(HT_MIN)) u_limit (
        .code     (cfg_ratio),
        .halftone (cfg_halftone),
        .step     (live_step_w),
        .clamped  (live_clamp_w)
    );

    always_comb begin
        start_w = in_valid && in_line_start;
        if (start_w) begin
            cur.step     = live_step_w;
            cur.clamped  = live_clamp_w;
            cur.halftone = cfg_halftone;
            cur.emit     = emit_mode_e'(cfg_emit);
        end else begin
            cur = cfg_q;
        end
    end

    shrink_phase #(.RATIO_W(RATIO_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (in_valid),
        .restart (start_w),
        .step    (cur.step),
        .keep    (keep_w)
    );

    shrink_black_carry u_carry (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (in_valid),
        .restart (start_w),
        .keep    (keep_w),
        .binary  (!cur.halftone),
        .bit_in  (in_pix[0]),
        .merged  (merged_w)
    );

    always_comb begin
        cfg_d      = cur;
        o_d        = o_q;
        o_d.valid  = in_valid && ((cur.emit == EMIT_MASKED) || keep_w);
        o_d.keep   = keep_w;
        o_d.clamped = cfg_d.clamped;
        if (in_valid) begin
            if (keep_w && !cur.halftone) o_d.pix = {{(PIX_W-1){1'b0}}, merged_w};
            else                         o_d.pix = in_pix;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{step: FULL, clamped: 1'b0, halftone: 1'b0, emit: EMIT_GATED};
            o_q   <= '0;
        end else begin
            cfg_q <= cfg_d;
            o_q   <= o_d;
        end
    end

    assign out_valid   = o_q.valid;
    assign out_keep    = o_q.keep;
    assign out_pix     = o_q.pix;
    assign out_clamped = o_q.clamped;

    // R1: an idle input cycle yields an idle output cycle.
    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R4: the line-start pixel is always kept.
    a_r4_line_head: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_line_start) |=> (out_valid && out_keep));
    // R3: a unit step drops nothing.
    a_r3_pass_all: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_line_start && cfg_q.step == FULL) |=> out_keep);
    // R8: a kept pixel is always strobed.
    a_r8_keep_strobed: assert property (@(posedge clk) disable iff (!rst_n)
        out_keep |-> out_valid);
    // R9: masked mode strobes every pixel.
    a_r9_masked_all: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_line_start && cfg_q.emit == EMIT_MASKED) |=> out_valid);
    // R5: kept binary pixels carry only bit 0.
    a_r5_binary_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_w && !cur.halftone) |=> (out_pix[PIX_W-1:1] == '0));
    // R6: halftone lines never run below the step floor.
    a_r6_step_floor: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.halftone |-> (int'(cfg_q.step) >= HT_MIN));
    // R7: configuration only moves on a line-start pixel.
    a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_line_start) |=> $stable(cfg_q));
endmodule

// File: tb/hscan_shrinker_test.sv
module hscan_shrinker_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_line_start = 1'b0;
    logic [5:0] in_pix = '0;
    logic [6:0] cfg_ratio = '0;
    logic       cfg_halftone = 1'b0, cfg_emit = 1'b0;
    logic       out_valid, out_keep, out_clamped;
    logic [5:0] out_pix;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hscan_shrinker uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_line_start(in_line_start),
        .in_pix(in_pix), .cfg_ratio(cfg_ratio), .cfg_halftone(cfg_halftone),
        .cfg_emit(cfg_emit), .out_valid(out_valid), .out_keep(out_keep),
        .out_pix(out_pix), .out_clamped(out_clamped)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic px(input bit v, input bit ls, input logic [5:0] p);
        in_valid = v; in_line_start = ls; in_pix = p;
        @(posedge clk); #2;
    endtask

    function automatic logic [5:0] pattern(input int pat, input int i);
        if (pat == 0) return 6'((i * 7 + 3) % 64);
        return ((i % 5) == 2) ? 6'h3 : 6'h2;
    endfunction

    // One line through the block, each pixel compared with a model built from R2, R5, R6, R8, R9.
    task automatic run_line(input int code, input bit ht, input bit mask, input int n,
                            input int pat, input bit twist, input string req, output int kept);
        int s; bit carry; bit k; logic [5:0] p, ep; int ev;
        s = code + 1;
        if (ht && s < 64) s = 64;
        carry = 0; kept = 0;
        cfg_ratio = 7'(code); cfg_halftone = ht; cfg_emit = mask;
        for (int i = 0; i < n; i++) begin
            p = pattern(pat, i);
            px(1'b1, i == 0, p);
            if (i == 0) begin
                chk({req, " R6 clamp flag"}, out_clamped, int'(ht && (code + 1) < 64));
                if (twist) begin // R7: later changes are ignored
                    cfg_ratio = 7'(code ^ 7'h55); cfg_halftone = !ht; cfg_emit = !mask;
                end
            end
            k = (i == 0) || (((i * s) / 128) != (((i - 1) * s) / 128));
            if (i == 0) carry = 0;
            ep = p;
            if (k) begin
                kept++;
                if (!ht) ep = {5'b0, p[0] | carry};
                carry = 0;
            end else if (!ht) begin
                carry = carry | p[0];
            end
            ev = ((mask || k) ? 256 : 0) + (k ? 128 : 0) + ep;
            chk(req, {out_valid, out_keep, 1'b0, out_pix}, ev);
        end
        px(1'b0, 1'b0, 6'h0);
        chk({req, " R1 idle"}, out_valid, 0);
        cfg_ratio = 7'(code); cfg_halftone = ht; cfg_emit = mask;
    endtask

    task automatic t_reset;
        chk("R1 reset valid", out_valid, 0);
        chk("R1 reset keep", out_keep, 0);
        chk("R1 reset pix", out_pix, 0);
        chk("R1 reset clamped", out_clamped, 0);
    endtask

    task automatic t_ratio_sweep;
        int kept;
        run_line(63, 0, 0, 50, 0, 0, "R2 half", kept);
        chk("R2 half count", kept, 1 + (49 * 64) / 128);
        run_line(36, 0, 0, 90, 0, 0, "R2 step37", kept);
        chk("R2 step37 count", kept, 1 + (89 * 37) / 128);
        run_line(0, 0, 0, 260, 0, 0, "R4 min ratio", kept);
        chk("R4 min ratio count", kept, 3);
    endtask

    task automatic t_pass_all;
        int kept;
        run_line(127, 1, 0, 40, 0, 0, "R3 unity", kept);
        chk("R3 unity count", kept, 40);
    endtask

    task automatic t_black;
        int kept;
        run_line(15, 0, 0, 60, 1, 0, "R5 black carry", kept);
        run_line(40, 0, 1, 45, 1, 0, "R5 black masked", kept);
    endtask

    task automatic t_clamp;
        int kept;
        run_line(10, 1, 0, 30, 0, 0, "R6 halftone clamp", kept);
        chk("R6 clamp count", kept, 1 + (29 * 64) / 128);
        run_line(10, 0, 0, 30, 0, 0, "R6 binary no clamp", kept);
    endtask

    task automatic t_mask;
        int kept;
        run_line(50, 1, 1, 40, 0, 0, "R9 masked halftone", kept);
        run_line(50, 0, 0, 40, 0, 0, "R8 gated binary", kept);
    endtask

    task automatic t_latch;
        int kept;
        run_line(20, 0, 0, 50, 0, 1, "R7 latch", kept);
        chk("R7 latch count", kept, 1 + (49 * 21) / 128);
    endtask

    task automatic t_long;
        int kept;
        run_line(36, 0, 0, 8192, 0, 0, "R10 long line", kept);
        chk("R10 long count", kept, 1 + (8191 * 37) / 128);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        rst_n = 1'b1;
        px(1'b0, 1'b0, 6'h0);
        t_ratio_sweep();
        t_pass_all();
        t_black();
        t_clamp();
        t_mask();
        t_latch();
        t_long();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule